// File: doc/BRIEF.md
# Host Burst-Command Register Bank

This block is a small register bank that sits on a processor bus, on the host side. It lets software start word-burst reads or writes toward a client interface. Software writes one control register that holds a burst length, a direction, a repeated-write flag and a soft-reset bit for the client. A write that carries a nonzero length produces a single-cycle command, and that command carries the length, the direction and the repeat flag.

A second register holds an interrupt threshold and three enable bits. The block takes in the number of empty entries in the write FIFO and a status flag from each FIFO. It derives a partial-empty status by comparing the empty count against twice the threshold. It then merges the enabled status terms into one registered interrupt line. Reads return the register addressed by the bank select and word address. Reserved bits read as zero, and so does any unmapped location.

Top module: `hbc_regbank`

## Requirements
- R1: After reset, the control register reads 0x0000 and the interrupt-enable register reads 0x2000. The outputs `irq`, `cmd_valid` and `client_rst` are all 0.
- R2: The control register is reached at bank select 0 with word address 0, and the interrupt-enable register at bank select 0 with word address 1. A write to any other bank or word address changes nothing, and reads from those locations return 0.
- R3: The control register holds the burst length in bits [12:4], the repeat flag in bit [3], the client reset in bit [2] and the direction in bit [0] (0 = write, 1 = read). Bits [15:13] and [1] are ignored on write and read back as 0.
- R4: A control-register write whose burst length is nonzero raises `cmd_valid` for exactly the one cycle after the write edge. During that cycle, `cmd_len` and `cmd_read` show the written length and direction. Back-to-back writes give back-to-back pulses.
- R5: A control-register write whose burst length is 0 never raises `cmd_valid`.
- R6: `cmd_repeat` is 1 on a command only when bit [3] was written as 1 and the direction is write. A read command always has `cmd_repeat` = 0.
- R7: `client_rst` follows control bit [2]. Once set, it stays at 1 through idle cycles and through writes to other locations, and only a control write with bit [2] = 0 clears it.
- R8: The interrupt-enable register holds the threshold in bits [15:8], the partial-empty enable in bit [7], the write-FIFO enable in bit [1] and the read-FIFO enable in bit [0]. All other bits are ignored on write and read as 0.
- R9: `wf_pempty` is 1 exactly when `wf_empty_cnt` is at least twice the programmed threshold. A threshold of 0 always gives 1.
- R10: `irq` is the registered OR of three terms: (partial-empty enable AND `wf_pempty`), (write-FIFO enable AND `wf_flag`), and (read-FIFO enable AND `rf_flag`). It reflects the values present one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write access |
| bus_sel | input | BANK_W (4) | Bank select |
| bus_addr | input | ADDR_W (2) | Word address inside the bank |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed location (combinational) |
| wf_empty_cnt | input | CNT_W (10) | Number of empty write-FIFO entries |
| wf_flag | input | 1 | Write-FIFO status flag |
| rf_flag | input | 1 | Read-FIFO status flag |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_len | output | 9 | Burst length in 32-bit words |
| cmd_read | output | 1 | Command direction, 1 = read |
| cmd_repeat | output | 1 | Command is a repeated burst write |
| client_rst | output | 1 | Soft reset held toward the client |
| wf_pempty | output | 1 | Write-FIFO partial-empty status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the exact edges of the partial-empty comparison. The bench has to reach both the threshold-doubled boundary and the point just below it, at the low end of the threshold range (zero) and at the high end (255, where twice the value needs a wider compare than the field). The stimulus programs each threshold through the bus and then steps the empty count across 2×T−1 and 2×T. The interrupt is then driven through all 64 pairings of enable pattern and status pattern, with the partial-empty term controlled through the count. A behavioural model is compared on every clock, so the one-cycle interrupt latency and the pulse timing are checked on each edge rather than sampled once.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  localparam int REG_W    = 16;
  localparam int LEN_W    = 9;
  localparam int LEN_LSB  = 4;
  localparam int REP_BIT  = 3;
  localparam int CRST_BIT = 2;
  localparam int DIR_BIT  = 0;
  localparam int THR_W    = 8;
  localparam int THR_LSB  = 8;
  localparam int PE_BIT   = 7;
  localparam int WF_BIT   = 1;
  localparam int RF_BIT   = 0;
  localparam logic [THR_W-1:0] THR_RST = 8'h20;

  typedef enum logic [1:0] {
    SLOT_CTL  = 2'd0,
    SLOT_IEN  = 2'd1,
    SLOT_NONE = 2'd2
  } slot_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             rep;
    logic             crst;
    logic             rd;
  } ctl_t;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic             pe_en;
    logic             wf_en;
    logic             rf_en;
  } ien_t;

  function automatic ctl_t ctl_unpack(input logic [REG_W-1:0] w);
    ctl_t c;
    c.len  = w[LEN_LSB +: LEN_W];
    c.rep  = w[REP_BIT];
    c.crst = w[CRST_BIT];
    c.rd   = w[DIR_BIT];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = c.len;
    w[REP_BIT]          = c.rep;
    w[CRST_BIT]         = c.crst;
    w[DIR_BIT]          = c.rd;
    return w;
  endfunction

  function automatic ien_t ien_unpack(input logic [REG_W-1:0] w);
    ien_t e;
    e.thr   = w[THR_LSB +: THR_W];
    e.pe_en = w[PE_BIT];
    e.wf_en = w[WF_BIT];
    e.rf_en = w[RF_BIT];
    return e;
  endfunction

  function automatic logic [REG_W-1:0] ien_pack(input ien_t e);
    logic [REG_W-1:0] w;
    w = '0;
    w[THR_LSB +: THR_W] = e.thr;
    w[PE_BIT]           = e.pe_en;
    w[WF_BIT]           = e.wf_en;
    w[RF_BIT]           = e.rf_en;
    return w;
  endfunction

  // Partial-empty test: empty count reaches twice the threshold.
  function automatic logic pempty_hit(input logic [REG_W-1:0] cnt,
                                      input logic [THR_W-1:0] thr);
    logic [REG_W-1:0] twice;
    twice = {{(REG_W-THR_W-1){1'b0}}, thr, 1'b0};
    return cnt >= twice;
  endfunction

  function automatic ien_t ien_reset();
    ien_t e;
    e       = '0;
    e.thr   = THR_RST;
    return e;
  endfunction

endpackage

// File: rtl/hbc_decode.sv
module hbc_decode
  import hbc_pkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int ADDR_W  = 2,
  parameter int BANK_ID = 0
) (
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic [BANK_W-1:0] bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  output slot_e             slot,
  output logic              ctl_wr_hit,
  output logic              ien_wr_hit
);
  localparam logic [BANK_W-1:0] BANK_V = BANK_W'(BANK_ID);
  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IEN_A  = ADDR_W'(1);

  logic bank_hit;
  logic wr_acc;

  assign bank_hit = (bus_sel == BANK_V);
  assign wr_acc   = bus_cs && bus_wr;

  always_comb begin
    slot = SLOT_NONE;
    if (bank_hit) begin
      if (bus_addr == CTL_A)      slot = SLOT_CTL;
      else if (bus_addr == IEN_A) slot = SLOT_IEN;
    end
  end

  assign ctl_wr_hit = wr_acc && (slot == SLOT_CTL);
  assign ien_wr_hit = wr_acc && (slot == SLOT_IEN);

endmodule

// File: rtl/hbc_ctrl_reg.sv
module hbc_ctrl_reg
  import hbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl_q,
  output logic             cmd_valid,
  output logic [LEN_W-1:0] cmd_len,
  output logic             cmd_read,
  output logic             cmd_repeat,
  output logic             client_rst
);
  ctl_t ctl_new;
  logic cmd_fire;

  assign ctl_new  = ctl_unpack(wdata);
  assign cmd_fire = ctl_wr && (ctl_new.len != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      cmd_valid  <= 1'b0;
      cmd_len    <= '0;
      cmd_read   <= 1'b0;
      cmd_repeat <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_new;
      cmd_valid <= cmd_fire;
      if (cmd_fire) begin
        cmd_len    <= ctl_new.len;
        cmd_read   <= ctl_new.rd;
        cmd_repeat <= ctl_new.rep && !ctl_new.rd;
      end
    end
  end

  assign client_rst = ctl_q.crst;

  a_r4_cmd_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(ctl_wr));
  a_r5_no_zero_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != '0));
  a_r6_no_repeat_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_read) |-> !cmd_repeat);
  a_r7_rst_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(client_rst));

endmodule

// File: rtl/hbc_irq.sv
module hbc_irq
  import hbc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [CNT_W-1:0] empty_cnt,
  input  logic             wf_flag,
  input  logic             rf_flag,
  output ien_t             ien_q,
  output logic             pempty,
  output logic             irq
);
  logic [REG_W-1:0] cnt_ext;
  logic pe_term, wf_term, rf_term, irq_next;

  assign cnt_ext  = REG_W'(empty_cnt);
  assign pempty   = pempty_hit(cnt_ext, ien_q.thr);
  assign pe_term  = ien_q.pe_en && pempty;
  assign wf_term  = ien_q.wf_en && wf_flag;
  assign rf_term  = ien_q.rf_en && rf_flag;
  assign irq_next = pe_term || wf_term || rf_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= ien_reset();
      irq   <= 1'b0;
    end else begin
      if (ien_wr) ien_q <= ien_unpack(wdata);
      irq <= irq_next;
    end
  end

  a_r9_zero_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q.thr == '0) |-> pempty);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pempty) && !$past(wf_flag) && !$past(rf_flag)) |-> !irq);
  a_r10_rf_path: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ien_q.rf_en && rf_flag) |-> irq);

endmodule

// File: rtl/hbc_regbank.sv
module hbc_regbank
  import hbc_pkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int ADDR_W  = 2,
  parameter int BANK_ID = 0,
  parameter int CNT_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic [BANK_W-1:0] bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [CNT_W-1:0]  wf_empty_cnt,
  input  logic              wf_flag,
  input  logic              rf_flag,
  output logic              cmd_valid,
  output logic [8:0]        cmd_len,
  output logic              cmd_read,
  output logic              cmd_repeat,
  output logic              client_rst,
  output logic              wf_pempty,
  output logic              irq
);
  slot_e slot;
  logic  ctl_wr_hit, ien_wr_hit;
  ctl_t  ctl_q;
  ien_t  ien_q;

  hbc_decode #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .BANK_ID(BANK_ID)) u_decode (
    .bus_cs     (bus_cs),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_addr   (bus_addr),
    .slot       (slot),
    .ctl_wr_hit (ctl_wr_hit),
    .ien_wr_hit (ien_wr_hit)
  );

  hbc_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr_hit),
    .wdata      (bus_wdata),
    .ctl_q      (ctl_q),
    .cmd_valid  (cmd_valid),
    .cmd_len    (cmd_len),
    .cmd_read   (cmd_read),
    .cmd_repeat (cmd_repeat),
    .client_rst (client_rst)
  );

  hbc_irq #(.CNT_W(CNT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ien_wr    (ien_wr_hit),
    .wdata     (bus_wdata),
    .empty_cnt (wf_empty_cnt),
    .wf_flag   (wf_flag),
    .rf_flag   (rf_flag),
    .ien_q     (ien_q),
    .pempty    (wf_pempty),
    .irq       (irq)
  );

  always_comb begin
    unique case (slot)
      SLOT_CTL: bus_rdata = ctl_pack(ctl_q);
      SLOT_IEN: bus_rdata = ien_pack(ien_q);
      default:  bus_rdata = '0;
    endcase
  end

  a_r3_ctl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_CTL) |-> (bus_rdata[15:13] == 3'b000 && !bus_rdata[1]));
  a_r8_ien_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_IEN) |-> (bus_rdata[6:2] == 5'b00000));
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel != BANK_W'(BANK_ID)) |-> (bus_rdata == 16'h0000));

endmodule

// File: tb/hbc_regbank_bench.sv
`timescale 1ns/1ps
module hbc_regbank_bench;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_sel = '0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [CNT_W-1:0] wf_empty_cnt = '0;
  logic wf_flag = 1'b0, rf_flag = 1'b0;
  logic cmd_valid, cmd_read, cmd_repeat, client_rst, wf_pempty, irq;
  logic [8:0] cmd_len;

  always #2 clk = ~clk;

  hbc_regbank #(.CNT_W(CNT_W)) u_hbc_regbank (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wf_empty_cnt(wf_empty_cnt), .wf_flag(wf_flag),
    .rf_flag(rf_flag), .cmd_valid(cmd_valid), .cmd_len(cmd_len),
    .cmd_read(cmd_read), .cmd_repeat(cmd_repeat), .client_rst(client_rst),
    .wf_pempty(wf_pempty), .irq(irq)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // Behavioural model state
  int m_len, m_thr;
  bit m_rep, m_crst, m_rd, m_pe, m_wf, m_rf, m_irq;
  bit m_cv, m_crd, m_crep;
  int m_clen;

  function automatic bit model_pempty(int cnt, int thr);
    return cnt >= thr * 2;
  endfunction

  function automatic int model_rdata();
    if (bus_sel != 0) return 0;
    if (bus_addr == 0) return (m_len << 4) | (int'(m_rep) << 3) | (int'(m_crst) << 2) | int'(m_rd);
    if (bus_addr == 1) return (m_thr << 8) | (int'(m_pe) << 7) | (int'(m_wf) << 1) | int'(m_rf);
    return 0;
  endfunction

  task automatic model_reset();
    m_len = 0; m_rep = 0; m_crst = 0; m_rd = 0;
    m_thr = 32; m_pe = 0; m_wf = 0; m_rf = 0; m_irq = 0;
    m_cv = 0; m_clen = 0; m_crd = 0; m_crep = 0;
  endtask

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2/R3/R8", "bus_rdata", int'(bus_rdata), model_rdata());
    check("R4/R5", "cmd_valid", int'(cmd_valid), int'(m_cv));
    if (m_cv) begin
      check("R4", "cmd_len", int'(cmd_len), m_clen);
      check("R4", "cmd_read", int'(cmd_read), int'(m_crd));
      check("R6", "cmd_repeat", int'(cmd_repeat), int'(m_crep));
    end
    check("R7", "client_rst", int'(client_rst), int'(m_crst));
    check("R9", "wf_pempty", int'(wf_pempty), int'(model_pempty(int'(wf_empty_cnt), m_thr)));
    check("R10", "irq", int'(irq), int'(m_irq));
  endtask

  task automatic step();
    bit nirq, hit;
    int wd, len;
    @(posedge clk);
    nirq = (m_pe && model_pempty(int'(wf_empty_cnt), m_thr)) || (m_wf && wf_flag) || (m_rf && rf_flag);
    hit = bus_cs && bus_wr && (bus_sel == 0);
    wd = int'(bus_wdata);
    m_cv = 0;
    if (hit && bus_addr == 0) begin
      len = (wd >> 4) & 511;
      m_len = len; m_rep = wd[3]; m_crst = wd[2]; m_rd = wd[0];
      if (len != 0) begin
        m_cv = 1; m_clen = len; m_crd = wd[0]; m_crep = wd[3] && !wd[0];
      end
    end
    if (hit && bus_addr == 1) begin
      m_thr = (wd >> 8) & 255; m_pe = wd[7]; m_wf = wd[1]; m_rf = wd[0];
    end
    m_irq = nirq;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic bus_write(logic [3:0] sel, logic [1:0] addr, logic [15:0] d);
    bus_cs = 1; bus_wr = 1; bus_sel = sel; bus_addr = addr; bus_wdata = d;
    step();
    bus_cs = 0; bus_wr = 0; bus_wdata = 16'h0;
  endtask

  task automatic look(logic [3:0] sel, logic [1:0] addr);
    bus_sel = sel; bus_addr = addr;
    step();
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check("R1", "ctl reset", int'(bus_rdata), 16'h0000);
    check("R1", "irq reset", int'(irq), 0);
    check("R1", "cmd_valid reset", int'(cmd_valid), 0);
    check("R1", "client_rst reset", int'(client_rst), 0);
    look(4'd0, 2'd1);
    check("R1", "ien reset", int'(bus_rdata), 16'h2000);

    // R3/R4: reserved bits masked, read command of 5 words
    bus_write(4'd0, 2'd0, 16'hE053);
    check("R4", "pulse length", int'(cmd_valid), 1);
    look(4'd0, 2'd0);
    check("R3", "ctl readback", int'(bus_rdata), 16'h0051);
    check("R4", "pulse ends", int'(cmd_valid), 0);

    // R5: zero length, no command
    bus_write(4'd0, 2'd0, 16'h0008);
    check("R5", "zero length", int'(cmd_valid), 0);
    idle(2);

    // R6: 256-word repeated write, then same as read
    bus_write(4'd0, 2'd0, 16'h1008);
    check("R6", "repeat write", int'(cmd_repeat), 1);
    bus_write(4'd0, 2'd0, 16'h1009);
    check("R6", "repeat read", int'(cmd_repeat), 0);
    // R4: back-to-back pulses
    bus_write(4'd0, 2'd0, 16'h0010);
    bus_write(4'd0, 2'd0, 16'h0021);
    check("R4", "second pulse", int'(cmd_valid), 1);

    // R7: client reset held
    bus_write(4'd0, 2'd0, 16'h0004);
    idle(5);
    bus_write(4'd0, 2'd1, 16'h2000);
    bus_write(4'd3, 2'd0, 16'h0000);
    check("R7", "rst held", int'(client_rst), 1);
    bus_write(4'd0, 2'd0, 16'h0000);
    check("R7", "rst cleared", int'(client_rst), 0);

    // R2: unmapped writes/reads
    bus_write(4'd1, 2'd0, 16'hFFFF);
    bus_write(4'd0, 2'd2, 16'hFFFF);
    bus_write(4'd0, 2'd3, 16'hFFFF);
    check("R2", "unmapped read", int'(bus_rdata), 0);
    check("R2", "no stray cmd", int'(cmd_valid), 0);
    look(4'd0, 2'd0);
    check("R2", "ctl untouched", int'(bus_rdata), 16'h0000);

    // R8: ien layout
    bus_write(4'd0, 2'd1, 16'hFFFF);
    check("R8", "ien readback", int'(bus_rdata), 16'hFF83);

    // R9: threshold boundaries
    bus_write(4'd0, 2'd1, 16'h0800);
    wf_empty_cnt = 10'd15; step();
    check("R9", "thr8 cnt15", int'(wf_pempty), 0);
    wf_empty_cnt = 10'd16; step();
    check("R9", "thr8 cnt16", int'(wf_pempty), 1);
    bus_write(4'd0, 2'd1, 16'h0000);
    wf_empty_cnt = 10'd0; step();
    check("R9", "thr0 cnt0", int'(wf_pempty), 1);
    bus_write(4'd0, 2'd1, 16'hFF00);
    wf_empty_cnt = 10'd509; step();
    check("R9", "thr255 cnt509", int'(wf_pempty), 0);
    wf_empty_cnt = 10'd510; step();
    check("R9", "thr255 cnt510", int'(wf_pempty), 1);

    // R10: every enable/status combination
    for (int e = 0; e < 8; e++) begin
      bus_write(4'd0, 2'd1, 16'(16'h0400 | (e[2] << 7) | (e[1] << 1) | e[0]));
      for (int s = 0; s < 8; s++) begin
        wf_empty_cnt = s[2] ? 10'd8 : 10'd7;
        wf_flag = s[1]; rf_flag = s[0];
        step();
        step();
        check("R10", "irq combo", int'(irq), int'((e[2] && s[2]) || (e[1] && s[1]) || (e[0] && s[0])));
      end
    end
    wf_flag = 0; rf_flag = 0;
    idle(3);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule